// File: doc/BRIEF.md
# Ring Go-Bit Group Arbiter

This block decides when a ring node may put its own pending packet onto the ring. Traffic is split into eight arbitration groups. Every idle symbol carries one go bit per group. Every packet header names exactly one group, as a one-hot field. The arbiter watches the symbol stream as it passes the node. It collects go bits from passing idles in an accumulator, and it collects the groups of passing packets in a block register. From these it grants transmission and rewrites the go bits of the idles it forwards downstream.

Words the node accepts into its own input queue leave a gap in the outgoing stream. The arbiter fills that gap with an idle symbol, and may repeat the last idle it emitted. The packet payload, the queues, routing and CRC are handled elsewhere. The arbiter sees only the incoming symbol, the accept decision, the bypass-queue empty and full flags, and the pending packet's group. Every output is registered, so a symbol that arrives in cycle n appears on the output in cycle n+1.

Top module: `ring_go_arbiter`

## Requirements
- R1: While reset is held, and just after it is released, out_pkt_o, out_sop_o, out_data_o and tx_go_o are all 0. The accumulator and the block register are empty, and the arbiter starts in the non-blocked state.
- R2: An emitted idle word holds its go bits in out_data_o[7:0], with out_data_o[15:8] at zero. An input idle word (sym_pkt_i=0) holds its go bits in sym_data_i[7:0]. When nothing is pending, an arriving idle is forwarded with its go bits unchanged, one cycle later.
- R3: A packet word that is not accepted (sym_pkt_i=1, accept_i=0) is forwarded one cycle later with out_pkt_o=1. Its data and its start flag are unchanged. A header word carries the one-hot group in bits [15:8] and the destination in bits [7:0].
- R4: A node that is pending and not blocked grants when an idle arrives, if the bypass queue is empty and the last idle it emitted carried the pending group's go bit. Grant means tx_go_o=1 alongside that forwarded idle, whose go bits are the arriving ones.
- R5: If a pending node cannot grant at an arriving idle, it enters the blocked state. While blocked, it ORs the go bits of every arriving idle into the accumulator. It grants at an arriving idle once the bypass queue is empty and the accumulator, filled by earlier idles, holds the group's bit. That idle leaves carrying the accumulator ORed with its own go bits.
- R6: While a packet is pending, the group bits of every passing header are ORed into the block register. A blocked idle leaves with go bits (arriving OR accumulator) AND NOT block register. Headers that pass while nothing is pending are not recorded.
- R7: A grant clears both the accumulator and the block register and returns the node to the non-blocked state. A fall of pend_i does the same.
- R8: An accepted packet word (sym_pkt_i=1, accept_i=1) is replaced by an idle. That idle repeats the go bits of the last emitted idle if nothing is pending and the bypass queue is not full. Otherwise it carries all-zero go bits.
- R9: No grant is given in a cycle in which the bypass queue is not empty, even if the required go bit is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Ring clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_pkt_i | input | 1 | Arriving symbol is a packet word (1) or an idle (0) |
| sym_sop_i | input | 1 | Arriving packet word is a header |
| sym_data_i | input | 16 | Arriving symbol contents |
| accept_i | input | 1 | Arriving packet word is taken into the node's input queue |
| bypass_empty_i | input | 1 | Bypass queue is empty |
| bypass_full_i | input | 1 | Bypass queue is full |
| pend_i | input | 1 | Node has a packet waiting to be sent |
| pend_grp_i | input | 3 | Group index of the pending packet |
| out_pkt_o | output | 1 | Emitted symbol is a packet word |
| out_sop_o | output | 1 | Emitted packet word is a header |
| out_data_o | output | 16 | Emitted symbol contents |
| tx_go_o | output | 1 | Own packet follows the idle emitted in this cycle |

## Verification
The hardest case to reach is a grant taken through the blocked path while the accumulator holds go bits that the block register must mask. Reaching it needs a pending packet whose last emitted idle lacked its bit. A foreign-group header must then pass, followed by a rich idle and then a cycle with the bypass queue not empty. The bench runs this sequence for every group, using the neighbouring group as the blocker, and checks the masked and the merged go bits at each step. It then re-raises pend_i with the bypass queue not empty, which shows that the grant left the accumulator empty.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;
  localparam int NUM_GRP = 8;
  localparam int ADDR_W  = 8;
  localparam int SYM_W   = NUM_GRP + ADDR_W;
  localparam int GIDX_W  = $clog2(NUM_GRP);

  typedef logic [NUM_GRP-1:0] grp_t;

  function automatic grp_t grp_mask(input logic [GIDX_W-1:0] idx);
    grp_t m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ring_arb_go_accum.sv
module ring_arb_go_accum #(
  parameter int NUM_GRP = ring_arb_pkg::NUM_GRP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               acc_en_i,
  input  logic [NUM_GRP-1:0] go_i,
  input  logic               blk_en_i,
  input  logic [NUM_GRP-1:0] hdr_grp_i,
  output logic [NUM_GRP-1:0] acc_o,
  output logic [NUM_GRP-1:0] blk_o
);
  logic [NUM_GRP-1:0] acc_q, blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      blk_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      blk_q <= '0;
    end else begin
      if (acc_en_i) acc_q <= acc_q | go_i;
      if (blk_en_i) blk_q <= blk_q | hdr_grp_i;
    end
  end

  assign acc_o = acc_q;
  assign blk_o = blk_q;

  // R5
  acc_keeps_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> ((acc_q & $past(acc_q)) == $past(acc_q)));
endmodule

// File: rtl/ring_arb_tx_gate.sv
module ring_arb_tx_gate #(
  parameter int NUM_GRP = ring_arb_pkg::NUM_GRP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               is_idle_i,
  input  logic               pend_i,
  input  logic               bypass_empty_i,
  input  logic [NUM_GRP-1:0] req_i,
  input  logic [NUM_GRP-1:0] acc_i,
  input  logic [NUM_GRP-1:0] last_go_i,
  output logic               grant_o,
  output logic               block_now_o,
  output logic               wait_o
);
  logic wait_q, have_go;

  // blocked nodes rely on collected bits, idle nodes on the last emitted idle
  assign have_go     = wait_q ? |(acc_i & req_i) : |(last_go_i & req_i);
  assign grant_o     = is_idle_i & pend_i & bypass_empty_i & have_go;
  assign block_now_o = is_idle_i & pend_i & ~grant_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  wait_q <= 1'b0;
    else if (!pend_i || grant_o)  wait_q <= 1'b0;
    else if (block_now_o)         wait_q <= 1'b1;
  end

  assign wait_o = wait_q;

  // R7
  wait_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q |-> $past(pend_i));
endmodule

// File: rtl/ring_arb_sym_out.sv
module ring_arb_sym_out #(
  parameter int NUM_GRP = ring_arb_pkg::NUM_GRP,
  parameter int SYM_W   = ring_arb_pkg::SYM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sym_pkt_i,
  input  logic               sym_sop_i,
  input  logic [SYM_W-1:0]   sym_data_i,
  input  logic               accept_i,
  input  logic               pend_i,
  input  logic               bypass_full_i,
  input  logic [NUM_GRP-1:0] idle_go_i,
  input  logic               grant_i,
  output logic [NUM_GRP-1:0] last_go_o,
  output logic               out_pkt_o,
  output logic               out_sop_o,
  output logic [SYM_W-1:0]   out_data_o,
  output logic               tx_go_o
);
  localparam int PAD_W = SYM_W - NUM_GRP;

  logic [NUM_GRP-1:0] last_go_q, fill_go;
  logic               out_pkt_q, out_sop_q, tx_go_q;
  logic [SYM_W-1:0]   out_data_q;

  // gap left by an accepted word: extend previous idle only when quiet
  assign fill_go = (!pend_i && !bypass_full_i) ? last_go_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_pkt_q  <= 1'b0;
      out_sop_q  <= 1'b0;
      out_data_q <= '0;
      tx_go_q    <= 1'b0;
      last_go_q  <= '0;
    end else begin
      tx_go_q <= grant_i;
      if (!sym_pkt_i) begin
        out_pkt_q  <= 1'b0;
        out_sop_q  <= 1'b0;
        out_data_q <= {{PAD_W{1'b0}}, idle_go_i};
        last_go_q  <= idle_go_i;
      end else if (!accept_i) begin
        out_pkt_q  <= 1'b1;
        out_sop_q  <= sym_sop_i;
        out_data_q <= sym_data_i;
      end else begin
        out_pkt_q  <= 1'b0;
        out_sop_q  <= 1'b0;
        out_data_q <= {{PAD_W{1'b0}}, fill_go};
        last_go_q  <= fill_go;
      end
    end
  end

  assign last_go_o  = last_go_q;
  assign out_pkt_o  = out_pkt_q;
  assign out_sop_o  = out_sop_q;
  assign out_data_o = out_data_q;
  assign tx_go_o    = tx_go_q;

  // R8
  idle_extend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sym_pkt_i && accept_i && !pend_i && !bypass_full_i)
      |-> (!out_pkt_o && out_data_o[NUM_GRP-1:0] == $past(last_go_q)));

  // R3
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sym_pkt_i && !accept_i) |-> (out_pkt_o && out_data_o == $past(sym_data_i)));
endmodule

// File: rtl/ring_go_arbiter.sv
module ring_go_arbiter
  import ring_arb_pkg::*;
#(
  parameter int N_GRP  = NUM_GRP,
  parameter int DATA_W = SYM_W,
  localparam int GI_W  = $clog2(N_GRP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_pkt_i,
  input  logic              sym_sop_i,
  input  logic [DATA_W-1:0] sym_data_i,
  input  logic              accept_i,
  input  logic              bypass_empty_i,
  input  logic              bypass_full_i,
  input  logic              pend_i,
  input  logic [GI_W-1:0]   pend_grp_i,
  output logic              out_pkt_o,
  output logic              out_sop_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              tx_go_o
);
  logic [N_GRP-1:0] req_mask, in_go, hdr_grp, idle_go;
  logic [N_GRP-1:0] acc_q, blk_q, last_go;
  logic             is_idle, is_hdr, grant, block_now, wait_q;

  assign is_idle = ~sym_pkt_i;
  assign is_hdr  = sym_pkt_i & sym_sop_i & ~accept_i;
  assign in_go   = sym_data_i[N_GRP-1:0];
  assign hdr_grp = sym_data_i[DATA_W-1 -: N_GRP];

  for (genvar b = 0; b < N_GRP; b++) begin : g_req
    assign req_mask[b] = (pend_grp_i == GI_W'(b));
  end

  // per-group go bit leaving on a forwarded idle
  for (genvar b = 0; b < N_GRP; b++) begin : g_fwd
    assign idle_go[b] = grant     ? (in_go[b] | acc_q[b]) :
                        block_now ? ((in_go[b] | acc_q[b]) & ~blk_q[b]) :
                                    in_go[b];
  end

  ring_arb_tx_gate #(.NUM_GRP(N_GRP)) u_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .is_idle_i      (is_idle),
    .pend_i         (pend_i),
    .bypass_empty_i (bypass_empty_i),
    .req_i          (req_mask),
    .acc_i          (acc_q),
    .last_go_i      (last_go),
    .grant_o        (grant),
    .block_now_o    (block_now),
    .wait_o         (wait_q)
  );

  ring_arb_go_accum #(.NUM_GRP(N_GRP)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (grant | ~pend_i),
    .acc_en_i  (block_now),
    .go_i      (in_go),
    .blk_en_i  (pend_i & is_hdr),
    .hdr_grp_i (hdr_grp),
    .acc_o     (acc_q),
    .blk_o     (blk_q)
  );

  ring_arb_sym_out #(.NUM_GRP(N_GRP), .SYM_W(DATA_W)) u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sym_pkt_i     (sym_pkt_i),
    .sym_sop_i     (sym_sop_i),
    .sym_data_i    (sym_data_i),
    .accept_i      (accept_i),
    .pend_i        (pend_i),
    .bypass_full_i (bypass_full_i),
    .idle_go_i     (idle_go),
    .grant_i       (grant),
    .last_go_o     (last_go),
    .out_pkt_o     (out_pkt_o),
    .out_sop_o     (out_sop_o),
    .out_data_o    (out_data_o),
    .tx_go_o       (tx_go_o)
  );

  // R9
  grant_needs_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_go_o |-> ($past(bypass_empty_i) && $past(pend_i) && !out_pkt_o));

  // R7
  grant_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_go_o |-> (acc_q == '0 && blk_q == '0 && !wait_q));

  // R6
  blocked_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_pkt_o && !tx_go_o && $past(pend_i))
      |-> ((out_data_o[N_GRP-1:0] & $past(blk_q)) == '0));

  // R2
  idle_unchanged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sym_pkt_i && !pend_i)
      |-> (out_data_o == {{(DATA_W-N_GRP){1'b0}}, $past(in_go)}));
endmodule

// File: tb/sim_ring_go_arbiter.sv
`timescale 1ns/1ps
module sim_ring_go_arbiter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sym_pkt_i = 1'b0, sym_sop_i = 1'b0, accept_i = 1'b0;
  logic [15:0] sym_data_i = '0;
  logic        bypass_empty_i = 1'b1, bypass_full_i = 1'b0, pend_i = 1'b0;
  logic [2:0]  pend_grp_i = '0;
  logic        out_pkt_o, out_sop_o, tx_go_o;
  logic [15:0] out_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  ring_go_arbiter u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sym_pkt_i(sym_pkt_i), .sym_sop_i(sym_sop_i),
    .sym_data_i(sym_data_i), .accept_i(accept_i), .bypass_empty_i(bypass_empty_i),
    .bypass_full_i(bypass_full_i), .pend_i(pend_i), .pend_grp_i(pend_grp_i),
    .out_pkt_o(out_pkt_o), .out_sop_o(out_sop_o), .out_data_o(out_data_o),
    .tx_go_o(tx_go_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one symbol, wait for the registered result
  task automatic step(input bit pkt, input bit sop, input bit acc, input logic [15:0] d,
                      input bit pend, input logic [2:0] grp, input bit be, input bit bf);
    @(negedge clk_i);
    sym_pkt_i = pkt; sym_sop_i = sop; accept_i = acc; sym_data_i = d;
    pend_i = pend; pend_grp_i = grp; bypass_empty_i = be; bypass_full_i = bf;
    @(posedge clk_i);
    #1;
  endtask

  task automatic exp_idle(input string req, input logic [7:0] go, input bit tx);
    chk(!out_pkt_o && out_data_o == {8'h00, go} && tx_go_o == tx, req,
        {15'd0, out_pkt_o, out_data_o}, {15'd0, 1'b0, 8'h00, go});
    chk(tx_go_o == tx, req, {31'd0, tx_go_o}, {31'd0, tx});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk(out_pkt_o == 0 && out_sop_o == 0 && out_data_o == 0 && tx_go_o == 0, "R1",
        {14'd0, out_pkt_o, out_sop_o, out_data_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(out_pkt_o == 0 && out_data_o == 0 && tx_go_o == 0, "R1",
        {15'd0, out_pkt_o, out_data_o}, 32'd0);

    // R2 sweep all go patterns with nothing pending
    for (int v = 0; v < 256; v++) begin
      step(0, 0, 0, {8'hA5, 8'(v)}, 0, 3'd0, 1, 0);
      exp_idle("R2", 8'(v), 0);
    end

    // R3 packet words pass unchanged
    for (int v = 0; v < 16; v++) begin
      step(1, (v % 4) == 0, 0, 16'(v * 4099), 0, 3'd0, 1, 0);
      chk(out_pkt_o && out_sop_o == ((v % 4) == 0) && out_data_o == 16'(v * 4099) && !tx_go_o,
          "R3", {15'd0, out_pkt_o, out_data_o}, {15'd0, 1'b1, 16'(v * 4099)});
    end

    for (int g = 0; g < 8; g++) begin
      logic [7:0] gb, ob;
      gb = 8'(1 << g);
      ob = 8'(1 << ((g + 1) % 8));

      // R4 immediate grant from last emitted idle
      step(0, 0, 0, {8'h00, gb}, 0, 3'(g), 1, 0);
      exp_idle("R4", gb, 0);
      step(0, 0, 0, 16'h0000, 1, 3'(g), 1, 0);
      exp_idle("R4", 8'h00, 1);
      step(0, 0, 0, 16'h0000, 0, 3'(g), 1, 0);
      exp_idle("R2", 8'h00, 0);

      // R4 wrong bit in last idle: no immediate grant
      step(0, 0, 0, {8'h00, ob}, 0, 3'(g), 1, 0);
      step(0, 0, 0, 16'h0000, 1, 3'(g), 1, 0);
      exp_idle("R4", 8'h00, 0);
      step(0, 0, 0, 16'h0000, 0, 3'(g), 1, 0);

      // R5/R6/R9/R7 blocked path
      step(0, 0, 0, 16'h0000, 1, 3'(g), 1, 0);
      exp_idle("R5", 8'h00, 0);
      step(1, 1, 0, {ob, 8'h11}, 1, 3'(g), 1, 0);
      chk(out_pkt_o && out_data_o == {ob, 8'h11}, "R3", {16'd0, out_data_o}, {16'd0, ob, 8'h11});
      step(0, 0, 0, 16'h00FF, 1, 3'(g), 1, 0);
      exp_idle("R6", ~ob, 0);
      step(0, 0, 0, 16'h0000, 1, 3'(g), 0, 0);
      exp_idle("R9", ~ob, 0);
      step(0, 0, 0, 16'h0000, 1, 3'(g), 1, 0);
      exp_idle("R5", 8'hFF, 1);
      step(0, 0, 0, 16'h0000, 1, 3'(g), 0, 0);
      exp_idle("R7", 8'h00, 0);
      step(0, 0, 0, 16'h0000, 0, 3'(g), 1, 0);
      exp_idle("R7", 8'h00, 0);

      // R6 headers seen while not pending are not recorded
      step(1, 1, 0, {gb, 8'h22}, 0, 3'(g), 1, 0);
      step(0, 0, 0, {8'h00, gb}, 1, 3'(g), 1, 0);
      exp_idle("R6", gb, 0);
      step(0, 0, 0, 16'h0000, 1, 3'(g), 1, 0);
      exp_idle("R5", gb, 1);
      step(0, 0, 0, 16'h0000, 0, 3'(g), 1, 0);
    end

    // R8 idle extension over accepted words
    step(0, 0, 0, 16'h003C, 0, 3'd0, 1, 0);
    exp_idle("R2", 8'h3C, 0);
    step(1, 1, 1, 16'h8001, 0, 3'd0, 1, 0);
    exp_idle("R8", 8'h3C, 0);
    step(1, 0, 1, 16'h1234, 0, 3'd0, 1, 0);
    exp_idle("R8", 8'h3C, 0);
    step(1, 0, 1, 16'h5678, 0, 3'd0, 0, 1);
    exp_idle("R8", 8'h00, 0);
    step(1, 0, 1, 16'h9ABC, 0, 3'd0, 1, 0);
    exp_idle("R8", 8'h00, 0);
    step(0, 0, 0, 16'h0081, 0, 3'd0, 1, 0);
    exp_idle("R2", 8'h81, 0);
    step(1, 1, 1, 16'h0101, 1, 3'd2, 1, 0);
    exp_idle("R8", 8'h00, 0);
    step(0, 0, 0, 16'h0000, 0, 3'd0, 1, 0);
    exp_idle("R7", 8'h00, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule